// File: doc/BRIEF.md
# System Clock Mode Controller

This block derives the bus clock of a small processor system from two oscillators: a fast main clock and a slow sub clock. A software-visible control word selects one of seven operating modes. The main clock can be used undivided or divided by 2, 4, 8 or 16. The sub clock can drive the bus clock with the main oscillator left running (low-speed), or with the main oscillator switched off (low-power). The block comes out of reset dividing the main clock by 8. A stop-mode request forces that ratio back.

A mode change is not applied on the spot. The requested mode waits until the oscillator flags it depends on report stable. The bus clock then moves over without runt pulses. A divide ratio changes only at the end of a full output period. A change of source takes place through a handshake, so that the old source is silenced before the new one is gated on. A status output gives the mode the bus clock is really running in, and firmware polls it to learn when a switch has finished. The control port and the sequencing logic run on the main clock, and the oscillator models keep that clock running.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the status output is 3 (divide-by-8), the main oscillator enable is 1, and the bus clock period is 8 main-clock periods.
- R2: The control word has five bits: bit 0 lock, bits 2:1 ratio field, bit 3 sub select, bit 4 main halt. With bits 3 and 0 both clear, the ratio field picks the bus clock: 00 gives the undivided main clock, 01 gives main/2, 10 gives main/4 and 11 gives main/16. With bit 3 clear and bit 0 set, the bus clock is main/8 whatever the ratio field holds.
- R3: When bit 3 is set and bit 4 is clear, the bus clock equals the sub clock and the status reads 5 (low-speed). The main oscillator enable stays 1.
- R4: When bits 3 and 4 are both set, the bus clock equals the sub clock and the status reads 6 (low-power). The main oscillator enable drops to 0, but only after the main-clock path has stopped. It returns to 1 as soon as a different mode is requested.
- R5: A write with bit 4 set and bit 3 clear is ignored. The mode in effect and the bus clock period stay unchanged.
- R6: A one-cycle stop request sets bit 0 of the control word. In any main-clock mode the block then moves to divide-by-8 (status 3, period of 8 main-clock periods).
- R7: A request to leave divide-by-8 stays pending while the main-stable flag is low. The status and the bus clock stay at divide-by-8 until the flag rises, and the request is then carried out.
- R8: A request that enters or leaves low-speed mode stays pending until both the main-stable and the sub-stable flags are high.
- R9: The bus clock has no pulse, high or low, shorter than half a main-clock period. It is never driven by both sources at once, and a divide ratio changes only at an output period boundary.
- R10: The status output (0 undivided, 1 /2, 2 /4, 3 /8, 4 /16, 5 low-speed, 6 low-power) changes to a new mode only once the new source is running. While a source handover is in progress, it keeps showing the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Main oscillator clock; also clocks the control logic |
| sclk_i | input | 1 | Sub oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 5 | Control word value to write |
| stop_req_i | input | 1 | Stop-mode entry pulse; forces the lock bit |
| main_stable_i | input | 1 | Main oscillator reports stable |
| sub_stable_i | input | 1 | Sub oscillator reports stable |
| bclk_o | output | 1 | Bus clock |
| main_osc_en_o | output | 1 | Enable for the main oscillator |
| mode_o | output | 3 | Mode in effect |

## Verification
The bench walks the control word through every ratio field value, with the lock bit both clear and set, and through both sub-clock modes. From the measured bus-clock period it can tell a wrong ratio decode from a source mixup, since the sub period is not a power-of-two multiple of the main period. Directed sequences hold one stable flag low and confirm that a request from divide-by-8, or into low-speed, is held back and then carried out. They also cover the rejected halt-without-sub write and a stop pulse taken from a fast ratio. A pulse-width monitor runs the whole time and catches any runt that a handover produces.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  localparam int CTL_W     = 5;
  localparam int LOCK_BIT  = 0;
  localparam int RATIO_LO  = 1;
  localparam int SUB_BIT   = 3;
  localparam int HALT_BIT  = 4;
  localparam logic [CTL_W-1:0] CTL_RESET = 5'b00001;

  typedef enum logic [2:0] {
    M_DIV1  = 3'd0,
    M_DIV2  = 3'd1,
    M_DIV4  = 3'd2,
    M_DIV8  = 3'd3,
    M_DIV16 = 3'd4,
    M_LOSPD = 3'd5,
    M_LOPWR = 3'd6
  } mode_e;

  function automatic mode_e decode_ctl(input logic [CTL_W-1:0] c);
    mode_e m;
    if (c[SUB_BIT])       m = c[HALT_BIT] ? M_LOPWR : M_LOSPD;
    else if (c[LOCK_BIT]) m = M_DIV8;
    else begin
      case (c[RATIO_LO+1:RATIO_LO])
        2'b00:   m = M_DIV1;
        2'b01:   m = M_DIV2;
        2'b10:   m = M_DIV4;
        default: m = M_DIV16;
      endcase
    end
    return m;
  endfunction

  function automatic logic uses_sub(input mode_e m);
    return (m == M_LOSPD) || (m == M_LOPWR);
  endfunction

  // log2 of the main-clock divide ratio
  function automatic logic [2:0] mode_shift(input mode_e m);
    logic [2:0] s;
    case (m)
      M_DIV1:  s = 3'd0;
      M_DIV2:  s = 3'd1;
      M_DIV4:  s = 3'd2;
      M_DIV16: s = 3'd4;
      default: s = 3'd3;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sysclk_ctl_reg.sv
`timescale 1ns/1ps
module sysclk_ctl_reg
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             stop_req_i,
  output mode_e            req_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             wr_ok;

  // halting the main oscillator is meaningful only with the sub clock selected
  assign wr_ok = wr_en_i && !(wr_data_i[HALT_BIT] && !wr_data_i[SUB_BIT]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctl_q <= CTL_RESET;
    end else begin
      if (wr_ok) ctl_q <= wr_data_i;
      if (stop_req_i) ctl_q[LOCK_BIT] <= 1'b1;
    end
  end

  assign req_o = decode_ctl(ctl_q);

  p_stop_lock_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_req_i |=> ctl_q[LOCK_BIT]);

  p_bad_write_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_data_i[HALT_BIT] && !wr_data_i[SUB_BIT] && !stop_req_i)
      |=> $stable(ctl_q));
endmodule

// File: rtl/sysclk_main_div.sv
`timescale 1ns/1ps
module sysclk_main_div #(
  parameter int MAX_SHIFT = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       run_i,
  input  logic [2:0] shift_i,
  output logic       busy_o,
  output logic       clk_o
);
  localparam int CW = MAX_SHIFT;

  logic [CW-1:0] cnt_q;
  logic [2:0]    shift_q;
  logic          act_q, div_q, u_want_q, en_u_q;
  logic [CW:0]   n_full, half, nxt;
  logic [CW-1:0] n_last;
  logic          boundary;

  assign n_full   = (CW+1)'(1) << shift_q;
  assign n_last   = CW'(n_full - 1'b1);
  assign half     = n_full >> 1;
  assign nxt      = {1'b0, cnt_q} + 1'b1;
  assign boundary = !act_q || (cnt_q == n_last);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      shift_q  <= 3'd3;
      act_q    <= 1'b0;
      div_q    <= 1'b0;
      u_want_q <= 1'b0;
    end else if (boundary) begin
      cnt_q   <= '0;
      shift_q <= shift_i;
      if (run_i && shift_i != 3'd0 && !en_u_q) begin
        act_q    <= 1'b1;
        div_q    <= 1'b1;
        u_want_q <= 1'b0;
      end else begin
        act_q    <= 1'b0;
        div_q    <= 1'b0;
        u_want_q <= run_i && (shift_i == 3'd0);
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      div_q <= (nxt < half);
    end
  end

  // undivided path: gate changes only while the main clock is low
  always_ff @(negedge clk_i) begin
    if (rst_i) en_u_q <= 1'b0;
    else       en_u_q <= u_want_q;
  end

  assign clk_o  = div_q | (clk_i & en_u_q);
  assign busy_o = act_q | u_want_q | en_u_q;

  p_ratio_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_q && !boundary) |=> $stable(shift_q));
endmodule

// File: rtl/sysclk_sub_gate.sv
`timescale 1ns/1ps
module sysclk_sub_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic sclk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic on_o,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] en_q;

  always_ff @(negedge sclk_i) begin
    if (rst_i) en_q <= '0;
    else       en_q <= {en_q[SYNC_STAGES-2:0], run_i};
  end

  assign on_o  = en_q[SYNC_STAGES-1];
  assign clk_o = sclk_i & en_q[SYNC_STAGES-1];
endmodule

// File: rtl/sysclk_mode_seq.sv
`timescale 1ns/1ps
module sysclk_mode_seq
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  mode_e      req_i,
  input  logic       main_ok_i,
  input  logic       sub_ok_i,
  input  logic       main_busy_i,
  input  logic       sub_on_raw_i,
  output logic       run_main_o,
  output logic       run_sub_o,
  output logic [2:0] shift_o,
  output logic       osc_en_o,
  output mode_e      status_o
);
  mode_e                  tgt_q;
  logic [SYNC_STAGES-1:0] sub_sync_q;
  logic                   sub_on, need_m, need_s, gate_ok, tgt_sub, src_ready;

  assign sub_on  = sub_sync_q[SYNC_STAGES-1];
  assign tgt_sub = uses_sub(tgt_q);
  assign need_m  = (tgt_q == M_DIV8) || (tgt_q == M_LOPWR) ||
                   (tgt_q == M_LOSPD) || (req_i == M_LOSPD);
  assign need_s  = tgt_sub || uses_sub(req_i);
  assign gate_ok = (!need_m || main_ok_i) && (!need_s || sub_ok_i);
  assign src_ready = tgt_sub ? (sub_on && !main_busy_i)
                             : (main_busy_i && !sub_on && !run_sub_o);
  assign shift_o = mode_shift(tgt_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tgt_q      <= M_DIV8;
      status_o   <= M_DIV8;
      run_main_o <= 1'b0;
      run_sub_o  <= 1'b0;
      osc_en_o   <= 1'b1;
      sub_sync_q <= '0;
    end else begin
      sub_sync_q <= {sub_sync_q[SYNC_STAGES-2:0], sub_on_raw_i};
      if (tgt_q != req_i && gate_ok) tgt_q <= req_i;
      // each run line is released only after its source acknowledged it
      run_main_o <= tgt_sub ? (run_main_o && !main_busy_i)
                            : (run_main_o || (!run_sub_o && !sub_on));
      run_sub_o  <= tgt_sub ? (run_sub_o || (!run_main_o && !main_busy_i))
                            : (run_sub_o && !sub_on);
      if (src_ready) status_o <= tgt_q;
      osc_en_o <= !(tgt_q == M_LOPWR && req_i == M_LOPWR &&
                    !main_busy_i && !run_main_o);
    end
  end

  p_one_source_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(main_busy_i && sub_on));

  p_hold_div8_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (tgt_q == M_DIV8 && req_i != M_DIV8 && !main_ok_i) |=> tgt_q == M_DIV8);

  p_lospd_gate_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (tgt_q != M_LOSPD && req_i == M_LOSPD && !(main_ok_i && sub_ok_i))
      |=> tgt_q != M_LOSPD);

  p_osc_off_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !osc_en_o |-> !main_busy_i);
endmodule

// File: rtl/sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter int MAX_SHIFT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mclk_i,
  input  logic             sclk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             stop_req_i,
  input  logic             main_stable_i,
  input  logic             sub_stable_i,
  output logic             bclk_o,
  output logic             main_osc_en_o,
  output logic [2:0]       mode_o
);
  mode_e      req, status;
  logic       run_main, run_sub, main_busy, sub_on_raw;
  logic       main_clk, sub_clk;
  logic [2:0] shift;

  sysclk_ctl_reg u_reg (
    .clk_i(mclk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .stop_req_i(stop_req_i), .req_o(req)
  );

  sysclk_mode_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk_i(mclk_i), .rst_i(rst_i), .req_i(req),
    .main_ok_i(main_stable_i), .sub_ok_i(sub_stable_i),
    .main_busy_i(main_busy), .sub_on_raw_i(sub_on_raw),
    .run_main_o(run_main), .run_sub_o(run_sub), .shift_o(shift),
    .osc_en_o(main_osc_en_o), .status_o(status)
  );

  sysclk_main_div #(.MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk_i(mclk_i), .rst_i(rst_i), .run_i(run_main), .shift_i(shift),
    .busy_o(main_busy), .clk_o(main_clk)
  );

  sysclk_sub_gate #(.SYNC_STAGES(SYNC_STAGES)) u_sub (
    .sclk_i(sclk_i), .rst_i(rst_i), .run_i(run_sub),
    .on_o(sub_on_raw), .clk_o(sub_clk)
  );

  assign bclk_o = main_clk | sub_clk;
  assign mode_o = status;
endmodule

// File: tb/sim_sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_mode_ctrl;
  logic       mclk = 1'b0, sclk = 1'b0, rst = 1'b1;
  logic       wr_en = 1'b0, stop_req = 1'b0;
  logic [4:0] wr_data = '0;
  logic       main_ok = 1'b0, sub_ok = 1'b0;
  logic       bclk, osc_en;
  logic [2:0] mode;

  int  errors = 0, checks = 0;
  bit  done = 1'b0, mon_on = 1'b0;
  real t_up = 0.0, t_dn = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;

  always #4  mclk = ~mclk;   // 125 MHz main clock
  always #44 sclk = ~sclk;   // 88 ns sub clock

  sysclk_mode_ctrl u0 (
    .mclk_i(mclk), .sclk_i(sclk), .rst_i(rst), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .stop_req_i(stop_req), .main_stable_i(main_ok),
    .sub_stable_i(sub_ok), .bclk_o(bclk), .main_osc_en_o(osc_en), .mode_o(mode)
  );

  // pulse-width monitor for R9
  always @(posedge bclk) begin
    if (mon_on && ($realtime - t_dn) < min_lo) min_lo = $realtime - t_dn;
    t_up = $realtime;
  end
  always @(negedge bclk) begin
    if (mon_on && ($realtime - t_up) < min_hi) min_hi = $realtime - t_up;
    t_dn = $realtime;
  end

  // {control word, expected mode, expected osc enable, expected period ns}
  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {5'b00010, 3'd1, 1'b1, 8'd16},
    {5'b00100, 3'd2, 1'b1, 8'd32},
    {5'b00110, 3'd4, 1'b1, 8'd128},
    {5'b00000, 3'd0, 1'b1, 8'd8},
    {5'b00111, 3'd3, 1'b1, 8'd64},
    {5'b01000, 3'd5, 1'b1, 8'd88},
    {5'b11000, 3'd6, 1'b0, 8'd88},
    {5'b00100, 3'd2, 1'b1, 8'd32},
    {5'b00001, 3'd3, 1'b1, 8'd64}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic write_ctl(input logic [4:0] d);
    @(negedge mclk);
    wr_en = 1'b1; wr_data = d;
    @(negedge mclk);
    wr_en = 1'b0;
  endtask

  task automatic period_ns(output int p);
    real t0;
    @(posedge bclk); t0 = $realtime;
    @(posedge bclk); p = $rtoi($realtime - t0 + 0.5);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge mclk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int p;
    cycles(20);
    rst = 1'b0;
    cycles(1);
    chk("R1 reset mode", int'(mode), 3);
    chk("R1 reset osc enable", int'(osc_en), 1);
    cycles(40);
    period_ns(p);
    chk("R1 reset period", p, 64);
    mon_on = 1'b1;

    // R7: leaving divide-by-8 waits for main stable
    write_ctl(5'b00010);
    cycles(150);
    chk("R7 pending mode", int'(mode), 3);
    period_ns(p);
    chk("R7 pending period", p, 64);
    main_ok = 1'b1; sub_ok = 1'b1;
    cycles(60);
    chk("R7 released mode", int'(mode), 1);
    period_ns(p);
    chk("R7 released period", p, 16);

    // table walk: R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      write_ctl(VEC[i][16:12]);
      cycles(150);
      chk($sformatf("R2/R3/R4 vec%0d mode", i), int'(mode), int'(VEC[i][11:9]));
      chk($sformatf("R4 vec%0d osc enable", i), int'(osc_en), int'(VEC[i][8]));
      period_ns(p);
      chk($sformatf("R2/R3 vec%0d period", i), p, int'(VEC[i][7:0]));
    end

    // R8: entering low-speed needs the sub flag too
    write_ctl(5'b00010);
    cycles(60);
    sub_ok = 1'b0;
    write_ctl(5'b01000);
    cycles(150);
    chk("R8 pending mode", int'(mode), 1);
    sub_ok = 1'b1;
    cycles(2);
    chk("R10 old mode during handover", int'(mode), 1);
    cycles(150);
    chk("R8 released mode", int'(mode), 5);
    period_ns(p);
    chk("R3 sub period", p, 88);

    // R8: leaving low-speed also waits
    main_ok = 1'b0;
    write_ctl(5'b00100);
    cycles(150);
    chk("R8 exit pending mode", int'(mode), 5);
    main_ok = 1'b1;
    cycles(150);
    chk("R8 exit released mode", int'(mode), 2);

    // R5: halt without sub is ignored
    write_ctl(5'b10000);
    cycles(150);
    chk("R5 ignored mode", int'(mode), 2);
    period_ns(p);
    chk("R5 ignored period", p, 32);

    // R6: stop request forces divide-by-8
    @(negedge mclk); stop_req = 1'b1;
    @(negedge mclk); stop_req = 1'b0;
    cycles(60);
    chk("R6 stop mode", int'(mode), 3);
    period_ns(p);
    chk("R6 stop period", p, 64);

    // R9: no runt pulses anywhere
    chk("R9 min high ps", $rtoi(min_hi * 1000.0 + 0.5) >= 4000 ? 1 : 0, 1);
    chk("R9 min low ps",  $rtoi(min_lo * 1000.0 + 0.5) >= 4000 ? 1 : 0, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule